// File: doc/BRIEF.md
# Two-Channel Output Compare Timer

A timer block for a peripheral cluster. A prescaler turns the system clock into counter ticks, one every (divider + 1) clocks. A shared up-counter advances on each tick, and a number of independent compare channels watch it. When the counter steps onto a channel's compare value, that channel does three things: it applies its output action to its pin (hold, drive high, drive low or toggle), it latches a sticky match flag, and it can request an interrupt.

Each channel can also reschedule itself. If its period register is nonzero, the hardware adds the period to the compare value on the same clock edge as the match. The sum wraps at the counter range, so repeated events stay exactly one period apart, wherever the counter rolls over and however late firmware responds.

All configuration goes through a single-cycle register write port. There is no data stream in this block, so every pin is a plain control or status signal. A write is taken on the edge where `wr_en` is high and is never stalled.

Top module: `oc_timer`

## Requirements
- R1: After reset the counter reads 0, and all pins, match flags and `irq` are 0. The reset values are divider 0, reload all ones, counter and master output enable off, every channel mode 00 with its enables off, and every compare and period register 0.
- R2: The counter changes only while the run bit (bit 0 of address 0) is 1. While it runs, it advances by one on every (divider + 1)-th clock. The divider is at address 1.
- R3: On a tick, a counter that is at or above the reload value (address 2) goes to 0. Otherwise it goes up by one.
- R4: A compare event happens on the edge where a tick moves the counter onto the channel's compare value. The channel's match flag is 1 from that edge onward.
- R5: On a compare event the pin state follows the channel mode, which is bits [1:0] of the channel config register: 00 keeps the state, 01 sets it to 1, 10 sets it to 0, 11 inverts it.
- R6: `irq` is 1 exactly when some channel has its match flag set and its interrupt enable (config bit 3) set.
- R7: A channel pin shows its state only when both its output enable (config bit 2) and the master output enable (bit 1 of address 0) are 1. Otherwise the pin is 0.
- R8: On a compare event with a nonzero period, the compare value becomes (compare + period) mod (reload + 1) on that same edge. With a zero period the compare value stays unchanged.
- R9: Writing address 3 clears the match flag of each channel n for which data bit n is 1. Flags written with 0 are kept. A match in the same cycle as a clear leaves the flag set.
- R10: Channel n has its registers at 4+3n (compare), 5+3n (period) and 6+3n (config). A software compare write in the same cycle as a match wins over the hardware reschedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register address |
| wr_data | input | CNT_W (16) | Register write data |
| count | output | CNT_W (16) | Current counter value |
| oc_pin | output | NCH (2) | Gated channel outputs |
| match_flag | output | NCH (2) | Sticky compare match flags |
| irq | output | 1 | Combined interrupt request |

## Verification
Two kinds of work can land on the same edge: a hardware compare event, and a software write to the same channel's flag-clear bit or compare register. The first case must keep the flag set, and the second must let the written compare value win over the rescheduled one. The bench runs a small reload range with period 2, so events come every few clocks. During that run it issues flag clears at a fixed stride and one compare write, which guarantees many collisions. It then compares counter, pins, flags and `irq` on every cycle against an arithmetic model that applies the "match wins" and "write wins" priorities.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_HIGH   = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_INVERT = 2'b11
  } oc_act_e;

  localparam int unsigned REG_CTRL      = 0;
  localparam int unsigned REG_DIV       = 1;
  localparam int unsigned REG_RELOAD    = 2;
  localparam int unsigned REG_CLEAR     = 3;
  localparam int unsigned REG_CH_BASE   = 4;
  localparam int unsigned REG_CH_STRIDE = 3;
endpackage

// File: rtl/oc_prescaler.sv
module oc_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] phase;

  assign tick = en && (phase >= div);

  always_ff @(posedge clk) begin
    if (!rst_n)   phase <= '0;
    else if (en)  phase <= tick ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/oc_counter.sv
module oc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic [W-1:0] count_nxt
);
  assign count_nxt = (count >= reload) ? '0 : count + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (tick)  count <= count_nxt;
  end
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] count_nxt,
  input  logic [W-1:0] reload,
  input  logic         moe,
  input  logic         ccr_wr,
  input  logic         per_wr,
  input  logic         cfg_wr,
  input  logic         clr,
  input  logic [W-1:0] wdata,
  output logic         pin,
  output logic         flag,
  output logic         irq_req,
  output logic         hit,
  output logic [W-1:0] ccr,
  output logic [W-1:0] per
);
  localparam int SW = W + 1;

  oc_act_e    act;
  logic       oe, ie, state;
  logic [SW-1:0] sum, span, wrapped;

  assign hit     = tick && (count_nxt == ccr);
  assign sum     = {1'b0, ccr} + {1'b0, per};
  assign span    = {1'b0, reload} + 1'b1;
  assign wrapped = (sum >= span) ? sum - span : sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccr <= '0;
      per <= '0;
      act <= ACT_HOLD;
      oe  <= 1'b0;
      ie  <= 1'b0;
    end else begin
      if (ccr_wr)                   ccr <= wdata;
      else if (hit && per != '0)    ccr <= wrapped[W-1:0];
      if (per_wr) per <= wdata;
      if (cfg_wr) begin
        act <= oc_act_e'(wdata[1:0]);
        oe  <= wdata[2];
        ie  <= wdata[3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      state <= 1'b0;
    end else begin
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (hit) begin
        case (act)
          ACT_HIGH:   state <= 1'b1;
          ACT_LOW:    state <= 1'b0;
          ACT_INVERT: state <= ~state;
          default:    state <= state;
        endcase
      end
    end
  end

  assign pin     = state & oe & moe;
  assign irq_req = flag & ie;
endmodule

// File: rtl/oc_timer.sv
module oc_timer
  import oc_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 2,
  localparam int ADDR_W = $clog2(REG_CH_BASE + REG_CH_STRIDE * NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count,
  output logic [NCH-1:0]    oc_pin,
  output logic [NCH-1:0]    match_flag,
  output logic              irq
);
  logic             cnt_en_q, moe_q, tick;
  logic [CNT_W-1:0] div_q, reload_q, count_nxt;
  logic [NCH-1:0]   hit_v, ccr_wr_v, irq_v;
  logic [NCH-1:0][CNT_W-1:0] ccr_v, per_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_en_q <= 1'b0;
      moe_q    <= 1'b0;
      div_q    <= '0;
      reload_q <= '1;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(REG_CTRL)) begin
        cnt_en_q <= wr_data[0];
        moe_q    <= wr_data[1];
      end
      if (wr_addr == ADDR_W'(REG_DIV))    div_q    <= wr_data;
      if (wr_addr == ADDR_W'(REG_RELOAD)) reload_q <= wr_data;
    end
  end

  oc_prescaler #(.W(CNT_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(cnt_en_q), .div(div_q), .tick(tick)
  );

  oc_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload_q),
    .count(count), .count_nxt(count_nxt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int unsigned BASE = REG_CH_BASE + REG_CH_STRIDE * g;
    logic per_wr, cfg_wr, clr;
    assign ccr_wr_v[g] = wr_en && (wr_addr == ADDR_W'(BASE));
    assign per_wr      = wr_en && (wr_addr == ADDR_W'(BASE + 1));
    assign cfg_wr      = wr_en && (wr_addr == ADDR_W'(BASE + 2));
    assign clr         = wr_en && (wr_addr == ADDR_W'(REG_CLEAR)) && wr_data[g];

    oc_channel #(.W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .count_nxt(count_nxt),
      .reload(reload_q), .moe(moe_q), .ccr_wr(ccr_wr_v[g]), .per_wr(per_wr),
      .cfg_wr(cfg_wr), .clr(clr), .wdata(wr_data), .pin(oc_pin[g]),
      .flag(match_flag[g]), .irq_req(irq_v[g]), .hit(hit_v[g]),
      .ccr(ccr_v[g]), .per(per_v[g])
    );
  end

  assign irq = |irq_v;
endmodule

// File: rtl/oc_timer_chk.sv
module oc_timer_chk #(
  parameter int CNT_W = 16,
  parameter int NCH   = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick,
  input logic                      cnt_en,
  input logic [CNT_W-1:0]          reload,
  input logic [CNT_W-1:0]          count,
  input logic [NCH-1:0]            hit_v,
  input logic [NCH-1:0]            ccr_wr_v,
  input logic [NCH-1:0][CNT_W-1:0] per_v,
  input logic [NCH-1:0][CNT_W-1:0] ccr_v,
  input logic [NCH-1:0]            match_flag
);
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count));

  a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count < reload) |=> count == $past(count) + 1'b1);

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count >= reload) |=> count == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_a
    a_r4_flag_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
      hit_v[g] |=> match_flag[g]);

    a_r8_zero_period_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_v[g] && per_v[g] == '0 && !ccr_wr_v[g]) |=> $stable(ccr_v[g]));
  end
endmodule

bind oc_timer oc_timer_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_en(cnt_en_q), .reload(reload_q),
  .count(count), .hit_v(hit_v), .ccr_wr_v(ccr_wr_v), .per_v(per_v),
  .ccr_v(ccr_v), .match_flag(match_flag)
);

// File: tb/tb_oc_timer.sv
module tb_oc_timer;
  localparam int CLK_NS = 10;
  localparam int W = 16;
  localparam int N = 2;
  localparam int AW = 4;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  count;
  logic [N-1:0]  oc_pin, match_flag;
  logic          irq;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  oc_timer #(.CNT_W(W), .NCH(N)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .oc_pin(oc_pin),
    .match_flag(match_flag), .irq(irq)
  );

  // Reference model, built from the requirements
  logic         m_en, m_moe;
  logic [W-1:0] m_div, m_rel, m_pc, m_cnt;
  logic [W-1:0] m_ccr [N];
  logic [W-1:0] m_per [N];
  logic [1:0]   m_act [N];
  logic [N-1:0] m_oe, m_ie, m_st, m_flag;

  always @(posedge clk) begin
    logic tk;
    logic [W-1:0] nx;
    if (!rst_n) begin
      m_en = 0; m_moe = 0; m_div = 0; m_rel = '1; m_pc = 0; m_cnt = 0;
      m_oe = 0; m_ie = 0; m_st = 0; m_flag = 0;
      for (int c = 0; c < N; c++) begin m_ccr[c] = 0; m_per[c] = 0; m_act[c] = 0; end
    end else begin
      tk = m_en && (m_pc >= m_div);
      nx = (m_cnt >= m_rel) ? 16'd0 : m_cnt + 16'd1;
      for (int c = 0; c < N; c++) begin
        logic h;
        h = tk && (nx == m_ccr[c]);
        if (h) begin
          m_flag[c] = 1'b1;
          case (m_act[c])
            2'b01: m_st[c] = 1'b1;
            2'b10: m_st[c] = 1'b0;
            2'b11: m_st[c] = ~m_st[c];
            default: ;
          endcase
          if (m_per[c] != 0)
            m_ccr[c] = W'((int'(m_ccr[c]) + int'(m_per[c])) % (int'(m_rel) + 1));
        end else if (wr_en && wr_addr == 3 && wr_data[c]) m_flag[c] = 1'b0;
        if (wr_en && wr_addr == AW'(4 + 3*c)) m_ccr[c] = wr_data;
        if (wr_en && wr_addr == AW'(5 + 3*c)) m_per[c] = wr_data;
        if (wr_en && wr_addr == AW'(6 + 3*c)) begin
          m_act[c] = wr_data[1:0]; m_oe[c] = wr_data[2]; m_ie[c] = wr_data[3];
        end
      end
      if (m_en) m_pc = tk ? 16'd0 : m_pc + 16'd1;
      if (tk) m_cnt = nx;
      if (wr_en && wr_addr == 0) begin m_en = wr_data[0]; m_moe = wr_data[1]; end
      if (wr_en && wr_addr == 1) m_div = wr_data;
      if (wr_en && wr_addr == 2) m_rel = wr_data;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  bit cmp_on = 0;
  always @(negedge clk) if (cmp_on && rst_n) begin
    check(count == m_cnt, "R2/R3 count", int'(count), int'(m_cnt));
    check(match_flag == m_flag, "R4/R9 flags", int'(match_flag), int'(m_flag));
    check(oc_pin == (m_st & m_oe & {N{m_moe}}), "R5/R7 pins",
          int'(oc_pin), int'(m_st & m_oe & {N{m_moe}}));
    check(irq == |(m_flag & m_ie), "R6 irq", int'(irq), int'(|(m_flag & m_ie)));
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    check(count == 0, "R1 count", int'(count), 0);
    check(oc_pin == 0, "R1 pins", int'(oc_pin), 0);
    check(match_flag == 0 && irq == 0, "R1 flags/irq", int'({match_flag, irq}), 0);

    // R2: no counting before the run bit
    wr(4, 1); wr(6, 4'b1011);
    repeat (20) @(negedge clk);
    check(count == 0, "R2 idle count", int'(count), 0);
    check(match_flag == 0, "R2 idle flag", int'(match_flag), 0);

    // R8 long-run scheduling: 200/500 periods, free-running counter
    do_reset();
    wr(4, 200); wr(5, 200); wr(6, 4'b0111);
    wr(7, 500); wr(8, 500); wr(9, 4'b0111);
    wr(0, 3);
    while (count != 16'd1000) @(negedge clk);
    check(oc_pin[0] == 1'b1, "R8 ch0 five toggles", int'(oc_pin[0]), 1);
    check(oc_pin[1] == 1'b0, "R8 ch1 two toggles", int'(oc_pin[1]), 0);
    check(match_flag == 2'b11, "R4 both flags", int'(match_flag), 3);
    // R9: clear only bit 0
    wr(3, 1);
    check(match_flag == 2'b10, "R9 selective clear", int'(match_flag), 2);

    // Near-exhaustive sweep with the per-cycle model
    cmp_on = 1;
    for (int dv = 0; dv < 3; dv++)
      for (int ri = 0; ri < 3; ri++)
        for (int md = 0; md < 16; md++) begin
          int rel;
          rel = (ri == 0) ? 5 : (ri == 1) ? 7 : 12;
          do_reset();
          wr(1, dv); wr(2, rel);
          wr(4, 1); wr(5, 2);
          wr(6, (md & 3) | 4 | ((md & 1) << 3));
          wr(7, rel); wr(8, ((md >> 2) == 2) ? 0 : rel); // R8 wrap / zero period
          wr(9, (md >> 2) | ((md & 2) << 1) | 8);
          wr(0, 1 | ((dv + md) & 1) << 1);                 // R7 master enable varies
          for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            if (i % 3 == 1) begin                          // R9 clear vs match
              wr_en = 1; wr_addr = 3; wr_data = W'(3);
            end else if (i == 20) begin                    // R10 write vs reschedule
              wr_en = 1; wr_addr = 4; wr_data = W'(rel / 2);
            end else wr_en = 0;
          end
          @(negedge clk); wr_en = 0;
        end
    cmp_on = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule